// File: doc/BRIEF.md
# Oversampling Serial Receiver with Phase Realignment

This block receives asynchronous serial characters on a single line. A sample enable pulses once per sample period, at sixteen times the bit rate, and the line is sampled only on those pulses. A character is one low start bit, then eight or nine data bits sent least-significant first, then one high stop bit. The value of every bit, the start bit included, is the majority of three samples taken at the middle of that bit.

Sender and receiver clocks may differ slightly. To keep the mid-bit samples centred, the receiver resets its sample phase on the falling edge of each start bit. It also moves the phase to the measured falling edge whenever a data bit that votes 0 follows one that votes 1. A finished character goes into a one-deep holding buffer, which is presented as a valid/ready output stream.

The buffer applies no back-pressure to the line. While `rx_valid` is high, `rx_data`, `rx_bit8` and `rx_frame_err` stay stable until a cycle with both `rx_valid` and `rx_ready` high. `rx_ready` has no effect while `rx_valid` is low. If a new character completes while the buffer is still full, that character is dropped and the overrun flag is raised.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_irq`, `rx_frame_err` and `rx_overrun` are all 0.
- R2: With `nine_bit_mode`=0 and a 16-sample bit period, the eight data bits after the start bit appear on `rx_data`, with the first received bit at bit 0.
- R3: A low level on the idle line counts as a start bit only if at least two of the samples at slots 8, 9 and 10 are 0. Slots are numbered 1 to 16, and slot 1 is the first low sample. Otherwise the receiver returns to idle and loads nothing.
- R4: Each bit takes the majority of its slot 8, 9 and 10 samples, so one opposite sample among the three does not change the received value.
- R5: When a data bit voting 0 follows one voting 1, the sample phase is moved to the falling edge seen in that bit. A sender whose bits are 17 samples long is then received correctly in 9-bit mode, provided it sends alternating data.
- R6: With `nine_bit_mode`=1, nine data bits are received. The ninth appears on `rx_bit8` and the first eight on `rx_data`.
- R7: With `nine_bit_mode`=0, `rx_bit8` equals bit 7 of `rx_data`.
- R8: A completed character sets `rx_valid` and is held there. The cycle after a cycle with `rx_valid` and `rx_ready` both high, `rx_valid` is 0. `rx_ready` has no effect while `rx_valid` is 0.
- R9: `rx_irq` is high exactly when `rx_valid` and `irq_enable` are both high.
- R10: If the stop bit votes 0, the character is still loaded and `rx_frame_err` is set. The handshake clears `rx_frame_err`.
- R11: If a character completes while `rx_valid` is high and no handshake happens in that cycle, `rx_overrun` is set and the buffered character stays as it was. The handshake clears `rx_overrun`.
- R12: A sender whose bits are 15 samples long, sending alternating data, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sample enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| nine_bit_mode | input | 1 | 1: nine data bits, 0: eight data bits |
| irq_enable | input | 1 | Enables `rx_irq` |
| rx_ready | input | 1 | Consumer takes the buffered character |
| rx_valid | output | 1 | Buffer holds a character |
| rx_data | output | 8 | First eight data bits of the buffered character |
| rx_bit8 | output | 1 | Ninth bit, or copy of bit 7 in 8-bit mode |
| rx_frame_err | output | 1 | Buffered character had a low stop bit |
| rx_overrun | output | 1 | A character was dropped because the buffer was full |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume `sample_tick` pulses at most once every few clocks, at intervals longer than the synchroniser depth. They also assume `nine_bit_mode` stays constant while a character is being received. The stimulus meets both conditions: the bench makes a tick every fourth clock, changes the line only just after a tick, and changes the mode only between characters. Glitches are placed only where R4 allows them to be harmless, on a 1 bit or on a 0 bit that follows a 0 bit. Sender bit lengths other than 16 are used only with alternating data, which gives the realignment of R5 an edge to act on.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_phase_e;
endpackage

// File: rtl/uart_os_sampler.sv
module uart_os_sampler #(
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              fall,
  output logic              vote,
  output logic [SLOT_W-1:0] age
);
  localparam logic [SLOT_W-1:0] AGE_MAX = SLOT_W'(OSR - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic [1:0]             hist_q;
  logic [SLOT_W-1:0]      age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  assign samp = sync_q[SYNC_STAGES-1];
  assign fall = tick && hist_q[0] && !samp;
  assign vote = (samp & hist_q[0]) | (samp & hist_q[1]) | (hist_q[0] & hist_q[1]);
  assign age  = fall ? '0 : ((age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      age_q  <= AGE_MAX;
    end else if (tick) begin
      hist_q <= {hist_q[0], samp};
      age_q  <= age;
    end
  end

  assert_fall_age_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> age_q == '0);
endmodule

// File: rtl/uart_os_framer.sv
module uart_os_framer
  import uart_os_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DATA_W = 8,
  localparam int SLOT_W = $clog2(OSR),
  localparam int CHAR_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall,
  input  logic              vote,
  input  logic [SLOT_W-1:0] age,
  input  logic              nine_bit,
  output logic              done,
  output logic              stop_bad,
  output logic [DATA_W-1:0] char_data,
  output logic              char_top
);
  localparam logic [SLOT_W-1:0] VOTE_SLOT = SLOT_W'(OSR / 2 + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OSR - 1);
  localparam int IDX_W = $clog2(CHAR_W + 1);

  rx_phase_e         phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              voted_q;
  logic              prev_vote_q;
  logic [IDX_W-1:0]  last_idx;
  logic              vote_now;
  logic              realign;
  logic [SLOT_W-1:0] realign_slot;

  assign last_idx     = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign vote_now     = tick && (slot_q == VOTE_SLOT) && !voted_q;
  assign realign      = prev_vote_q && !vote && (age != '0);
  assign realign_slot = (age >= SLOT_W'(OSR - 2)) ? LAST_SLOT : age + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= RX_IDLE;
      slot_q      <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      voted_q     <= 1'b0;
      prev_vote_q <= 1'b0;
      done        <= 1'b0;
      stop_bad    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (phase_q)
          RX_IDLE: begin
            if (fall) begin
              phase_q <= RX_START;
              slot_q  <= SLOT_W'(1);
              voted_q <= 1'b0;
            end
          end
          RX_START: begin
            if (vote_now) begin
              voted_q <= 1'b1;
              if (vote) phase_q <= RX_IDLE;
              slot_q <= slot_q + 1'b1;
            end else if (slot_q == LAST_SLOT) begin
              phase_q     <= RX_DATA;
              slot_q      <= '0;
              idx_q       <= '0;
              voted_q     <= 1'b0;
              prev_vote_q <= 1'b0;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (vote_now) begin
              voted_q     <= 1'b1;
              prev_vote_q <= vote;
              shreg_q     <= {vote, shreg_q[CHAR_W-1:1]};
              slot_q      <= realign ? realign_slot : slot_q + 1'b1;
            end else if (slot_q == LAST_SLOT) begin
              slot_q  <= '0;
              voted_q <= 1'b0;
              if (idx_q == last_idx) phase_q <= RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (vote_now) begin
              done     <= 1'b1;
              stop_bad <= !vote;
              phase_q  <= RX_IDLE;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
          default: phase_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign char_data = nine_bit ? shreg_q[DATA_W-1:0] : shreg_q[CHAR_W-1:1];
  assign char_top  = shreg_q[CHAR_W-1];

  assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == RX_START && vote_now && vote) |=> phase_q == RX_IDLE);
  assert_bit_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == RX_DATA |-> idx_q <= IDX_W'(DATA_W));
  assert_done_from_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase_q == RX_IDLE && $past(phase_q) == RX_STOP);
endmodule

// File: rtl/uart_os_holdbuf.sv
module uart_os_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_top,
  input  logic              in_bad,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              top,
  output logic              ferr,
  output logic              ovr
);
  logic pop;
  assign pop = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      top   <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load && (!valid || pop)) begin
      valid <= 1'b1;
      data  <= in_data;
      top   <= in_top;
      ferr  <= in_bad;
      ovr   <= 1'b0;
    end else if (pop) begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      ovr <= 1'b1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && $stable(data) && $stable(top));
  assert_pop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid && !ovr && !ferr);
  assert_overrun_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && load) |=> ovr && $stable(data));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic              nine_bit_mode,
  input  logic              irq_enable,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_frame_err,
  output logic              rx_overrun,
  output logic              rx_irq
);
  localparam int SLOT_W = $clog2(OSR);

  logic              fall;
  logic              vote;
  logic [SLOT_W-1:0] age;
  logic              done;
  logic              stop_bad;
  logic [DATA_W-1:0] char_data;
  logic              char_top;

  uart_os_sampler #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rxd(rxd),
    .fall(fall), .vote(vote), .age(age)
  );

  uart_os_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .fall(fall), .vote(vote),
    .age(age), .nine_bit(nine_bit_mode), .done(done), .stop_bad(stop_bad),
    .char_data(char_data), .char_top(char_top)
  );

  uart_os_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(done), .in_data(char_data),
    .in_top(char_top), .in_bad(stop_bad), .ready(rx_ready),
    .valid(rx_valid), .data(rx_data), .top(rx_bit8),
    .ferr(rx_frame_err), .ovr(rx_overrun)
  );

  assign rx_irq = rx_valid && irq_enable;

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_err || rx_overrun) |-> rx_valid);
endmodule

// File: tb/uart_os_rx_test.sv
`timescale 1ns/1ps
module uart_os_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine = 1'b0;
  logic       irq_en = 1'b0;
  logic       ready = 1'b0;
  logic       valid;
  logic [7:0] data;
  logic       bit8;
  logic       ferr;
  logic       ovr;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  int         div = 0;
  bit         finished = 1'b0;

  uart_os_rx uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .rxd(rxd),
    .nine_bit_mode(nine), .irq_enable(irq_en), .rx_ready(ready),
    .rx_valid(valid), .rx_data(data), .rx_bit8(bit8),
    .rx_frame_err(ferr), .rx_overrun(ovr), .rx_irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(input logic [8:0] b);
    return b[7:0];
  endfunction

  function automatic logic exp_top(input logic [8:0] b, input logic nb);
    return nb ? b[8] : b[7];
  endfunction

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk iff tick);
  endtask

  task automatic drive_bit(input logic v, input int blen, input bit glitch);
    for (int t = 0; t < blen; t++) begin
      rxd <= (glitch && t == 8) ? ~v : v;
      @(posedge clk iff tick);
    end
  endtask

  task automatic send_frame(input logic [8:0] b, input logic nb, input int blen,
                            input logic stopv, input int gbit);
    @(posedge clk iff tick);
    drive_bit(1'b0, blen, 1'b0);
    for (int k = 0; k < (nb ? 9 : 8); k++) drive_bit(b[k], blen, gbit == k);
    drive_bit(stopv, blen, 1'b0);
    rxd <= 1'b1;
    wait_ticks(24);
    @(negedge clk);
  endtask

  task automatic pop_and_check(input string tag);
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk({tag, " valid after handshake"}, valid, 0);
    chk({tag, " flags after handshake"}, {ferr, ovr}, 0);
  endtask

  task automatic frame_check(input string tag, input logic [8:0] b, input logic nb,
                             input int blen);
    nine = nb;
    send_frame(b, nb, blen, 1'b1, -1);
    chk({tag, " valid"}, valid, 1);
    chk({tag, " data"}, data, exp_data(b));
    chk({tag, " bit8"}, bit8, exp_top(b, nb));
    chk({tag, " frame_err"}, ferr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] b;
    logic       nb;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 valid", valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {ferr, ovr}, 0);
    rst_n = 1'b1;
    wait_ticks(20);

    // R8 ready with empty buffer has no effect
    @(negedge clk); ready = 1'b1; repeat (10) @(negedge clk); ready = 1'b0;
    chk("R8 ready while empty", valid, 0);

    // R2 basic 8-bit
    frame_check("R2 8bit a5", 9'h0A5, 1'b0, 16);
    chk("R7 bit8 copy", bit8, data[7]);
    // R9 irq follows enable
    chk("R9 irq off", irq, 0);
    @(negedge clk); irq_en = 1'b1; @(negedge clk);
    chk("R9 irq on", irq, 1);
    pop_and_check("R8");
    chk("R9 irq after pop", irq, 0);

    // R3 false start: short low pulse
    @(posedge clk iff tick);
    rxd <= 1'b0; wait_ticks(4); rxd <= 1'b1; wait_ticks(40);
    @(negedge clk);
    chk("R3 false start ignored", valid, 0);
    frame_check("R3 frame after false start", 9'h03C, 1'b0, 16);
    pop_and_check("R3");

    // R4 glitch on a 1 bit, and on a 0 bit after a 0 bit
    nine = 1'b0;
    send_frame(9'h0F1, 1'b0, 16, 1'b1, 0);
    chk("R4 glitch on one bit", data, 8'hF1);
    pop_and_check("R4a");
    send_frame(9'h001, 1'b0, 16, 1'b1, 2);
    chk("R4 glitch on zero bit", data, 8'h01);
    pop_and_check("R4b");

    // R6 nine-bit mode
    frame_check("R6 ninth bit", 9'h1C3, 1'b1, 16);
    pop_and_check("R6");

    // R5 slow sender, 17 samples per bit, 9-bit alternating
    frame_check("R5 slow sender", 9'h055, 1'b1, 17);
    pop_and_check("R5");
    // R12 fast sender, 15 samples per bit
    frame_check("R12 fast sender", 9'h155, 1'b1, 15);
    pop_and_check("R12");

    // R10 framing error
    nine = 1'b0;
    send_frame(9'h05A, 1'b0, 16, 1'b0, -1);
    chk("R10 valid on bad stop", valid, 1);
    chk("R10 frame_err", ferr, 1);
    chk("R10 data kept", data, 8'h5A);
    pop_and_check("R10");

    // R11 overrun
    send_frame(9'h011, 1'b0, 16, 1'b1, -1);
    send_frame(9'h0EE, 1'b0, 16, 1'b1, -1);
    chk("R11 overrun set", ovr, 1);
    chk("R11 data unchanged", data, 8'h11);
    chk("R11 still valid", valid, 1);
    pop_and_check("R11");

    // random characters, mixed modes
    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++) begin
      b  = 9'($urandom);
      nb = 1'($urandom);
      irq_en = 1'($urandom);
      frame_check("R2 random", b, nb, 16);
      chk("R9 random irq", irq, irq_en);
      chk("R11 random no overrun", ovr, 0);
      pop_and_check("R8 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule